// File: doc/BRIEF.md
# Suspend Refresh Mode Controller

This block sits on the memory-controller side and decides, from a system suspend-status signal, whether DRAM is kept alive by the normal refresh scheduler or by a low-power suspend refresh. When suspend status goes active, the block moves into suspend refresh on its own. Suspend refresh is either a held self-refresh request or a train of slow CBR refresh strobes. The slow strobes are timed from a free-running slow clock through a divider with a selectable ratio.

Leaving suspend refresh depends on the kind of resume. After a power-on-suspend resume with automatic exit enabled, hardware returns to normal refresh without help. After a suspend-to-RAM resume, or after a soft reset that pulsed suspend status, suspend refresh stays selected and memory cycles stay refused. This lasts until software writes a one to the normal-refresh-enable bit: bit 4 of the power-management control register at configuration address 0x7A. On every exit, the self-refresh request is dropped one cycle before the normal refresh scheduler is enabled again. A power-on reset behaves like a suspend-to-disk resume and starts in normal refresh with memory open.

Top module: `susp_refresh_ctrl`

## Requirements
- R1: After reset, refresh_mode_o=0, self_ref_req_o=0, cbr_req_o=0, mem_block_o=0 and norm_sched_en_o=1.
- R2: While sus_stat_ni is low (asserted), the block selects suspend refresh without any configuration write: refresh_mode_o=1, mem_block_o=1 and norm_sched_en_o=0, each within 6 clock cycles of the assertion.
- R3: On deassertion of sus_stat_ni with resume_pos_i=1 and auto_exit_en_i=1, the block returns to normal refresh within 8 cycles: refresh_mode_o=0, mem_block_o=0 and norm_sched_en_o=1, with no write needed.
- R4: On deassertion with resume_pos_i=0 (suspend-to-RAM) or auto_exit_en_i=0, refresh_mode_o and mem_block_o stay 1 until a write with cfg_we_i=1, cfg_addr_i=0x7A and cfg_wdata_i bit 4 = 1. A write to any other address, or a write with bit 4 = 0, leaves the block in suspend refresh.
- R5: The normal-refresh-enable bit is cleared by hardware while suspend status is asserted. A write of that bit during suspend does not let a suspend-to-RAM resume exit.
- R6: When mem_edo_i=0 (SDRAM), or when mem_edo_i=1 with edo_cbr_sel_i=0, self_ref_req_o is 1 for the whole time refresh_mode_o=1 and cbr_req_o never pulses.
- R7: When mem_edo_i=1 and edo_cbr_sel_i=1, self_ref_req_o stays 0 and cbr_req_o gives a one-cycle pulse on every 4*2^div_sel_i-th rising edge of slow_clk_i, counting from entry into suspend refresh. Slow-clock edges outside suspend refresh produce no pulse.
- R8: On every exit, refresh_mode_o and self_ref_req_o fall exactly one cycle before norm_sched_en_o rises, and mem_block_o falls together with norm_sched_en_o rising.
- R9: An assertion of sus_stat_ni while the block waits for software (a soft reset) keeps suspend refresh selected. The following suspend-to-RAM resume again needs the software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| sus_stat_ni | input | 1 | Suspend status, active low, asynchronous |
| resume_pos_i | input | 1 | 1: power-on-suspend resume, 0: suspend-to-RAM resume |
| auto_exit_en_i | input | 1 | Allows hardware exit to normal refresh on power-on-suspend resume |
| mem_edo_i | input | 1 | 1: EDO memory, 0: SDRAM |
| edo_cbr_sel_i | input | 1 | For EDO, 1 selects CBR suspend refresh, 0 selects self-refresh |
| div_sel_i | input | 2 | Slow refresh ratio, 4*2^div_sel_i slow edges per CBR strobe |
| slow_clk_i | input | 1 | Free-running slow timebase, asynchronous |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration write address |
| cfg_wdata_i | input | 8 | Configuration write data |
| refresh_mode_o | output | 1 | 1: suspend refresh selected |
| self_ref_req_o | output | 1 | Self-refresh request level |
| cbr_req_o | output | 1 | CBR refresh request strobe |
| mem_block_o | output | 1 | 1: memory cycles refused |
| norm_sched_en_o | output | 1 | Enables the normal refresh scheduler |

## Verification
The hardest state to reach is the software-wait state entered through a soft reset. It is only reached after a suspend entry, a resume on the suspend-to-RAM path, and then a second suspend-status pulse. The bench gets there by running through every combination of resume type, automatic-exit option and memory type. It drives decoy writes (wrong address, bit 4 clear, a write during suspend) before the real write. It then times the self-refresh release against the scheduler enable cycle by cycle. The CBR divider is swept over all four ratios with edge counts just past a multiple of the ratio.

// File: rtl/srm_pkg.sv
package srm_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_SUSPEND = 2'd1,
    ST_WAIT_SW = 2'd2,
    ST_EXIT    = 2'd3
  } srm_state_e;
endpackage

// File: rtl/srm_cfg_reg.sv
module srm_cfg_reg #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] PM_ADDR = 8'h7A,
  parameter int unsigned NRE_BIT  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hw_clr_i,
  output logic              nre_o
);
  logic nre_q;
  logic hit;
  logic unused_wdata;

  assign hit          = we_i && (addr_i == PM_ADDR);
  assign unused_wdata = ^wdata_i;

  // hardware clear wins over a software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       nre_q <= 1'b1;
    else if (hw_clr_i) nre_q <= 1'b0;
    else if (hit)      nre_q <= wdata_i[NRE_BIT];
  end

  assign nre_o = nre_q;
endmodule

// File: rtl/srm_fsm.sv
module srm_fsm
  import srm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sus_stat_ni,
  input  logic resume_pos_i,
  input  logic auto_exit_en_i,
  input  logic nre_i,
  output logic in_susp_o,
  output logic hw_clr_o,
  output logic sched_en_o
);
  logic [SYNC_STAGES-1:0] sus_sync_q;
  logic       susp_req;
  srm_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sus_sync_q <= '1;
    else         sus_sync_q <= {sus_sync_q[SYNC_STAGES-2:0], sus_stat_ni};
  end

  assign susp_req = !sus_sync_q[SYNC_STAGES-1];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL:  if (susp_req) state_d = ST_SUSPEND;
      ST_SUSPEND: if (!susp_req)
                    state_d = (resume_pos_i && auto_exit_en_i) ? ST_EXIT : ST_WAIT_SW;
      ST_WAIT_SW: if (susp_req)   state_d = ST_SUSPEND;
                  else if (nre_i) state_d = ST_EXIT;
      ST_EXIT:    state_d = susp_req ? ST_SUSPEND : ST_NORMAL;
      default:    state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_NORMAL;
    else         state_q <= state_d;
  end

  assign in_susp_o  = (state_q == ST_SUSPEND) || (state_q == ST_WAIT_SW);
  assign hw_clr_o   = (state_q == ST_SUSPEND);
  assign sched_en_o = (state_q == ST_NORMAL);
endmodule

// File: rtl/srm_cbr_timer.sv
module srm_cbr_timer #(
  parameter int unsigned DIV_BASE    = 4,
  parameter int unsigned SEL_W       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             slow_clk_i,
  output logic             strobe_o
);
  localparam int unsigned CNT_W = $clog2(DIV_BASE) + (1 << SEL_W);

  logic [SYNC_STAGES:0] slow_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     lim;
  logic                 edge_det;
  logic                 pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slow_q <= '0;
    else         slow_q <= {slow_q[SYNC_STAGES-1:0], slow_clk_i};
  end

  assign edge_det = slow_q[SYNC_STAGES-1] && !slow_q[SYNC_STAGES];
  assign lim      = CNT_W'(DIV_BASE) << div_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (!active_i) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (edge_det) begin
        if (cnt_q == lim - 1'b1) begin
          cnt_q   <= '0;
          pulse_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign strobe_o = pulse_q;
endmodule

// File: rtl/susp_refresh_ctrl.sv
module susp_refresh_ctrl #(
  parameter int unsigned CFG_ADDR_W  = 8,
  parameter int unsigned CFG_DATA_W  = 8,
  parameter logic [CFG_ADDR_W-1:0] PM_CTRL_ADDR = 8'h7A,
  parameter int unsigned NRE_BIT     = 4,
  parameter int unsigned DIV_BASE    = 4,
  parameter int unsigned SEL_W       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sus_stat_ni,
  input  logic                  resume_pos_i,
  input  logic                  auto_exit_en_i,
  input  logic                  mem_edo_i,
  input  logic                  edo_cbr_sel_i,
  input  logic [SEL_W-1:0]      div_sel_i,
  input  logic                  slow_clk_i,
  input  logic                  cfg_we_i,
  input  logic [CFG_ADDR_W-1:0] cfg_addr_i,
  input  logic [CFG_DATA_W-1:0] cfg_wdata_i,
  output logic                  refresh_mode_o,
  output logic                  self_ref_req_o,
  output logic                  cbr_req_o,
  output logic                  mem_block_o,
  output logic                  norm_sched_en_o
);
  logic nre;
  logic in_susp;
  logic hw_clr;
  logic sched_en;
  logic use_cbr;

  assign use_cbr = mem_edo_i && edo_cbr_sel_i;

  srm_cfg_reg #(
    .ADDR_W  (CFG_ADDR_W),
    .DATA_W  (CFG_DATA_W),
    .PM_ADDR (PM_CTRL_ADDR),
    .NRE_BIT (NRE_BIT)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .hw_clr_i (hw_clr),
    .nre_o    (nre)
  );

  srm_fsm #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sus_stat_ni    (sus_stat_ni),
    .resume_pos_i   (resume_pos_i),
    .auto_exit_en_i (auto_exit_en_i),
    .nre_i          (nre),
    .in_susp_o      (in_susp),
    .hw_clr_o       (hw_clr),
    .sched_en_o     (sched_en)
  );

  srm_cbr_timer #(
    .DIV_BASE    (DIV_BASE),
    .SEL_W       (SEL_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_cbr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (in_susp && use_cbr),
    .div_sel_i  (div_sel_i),
    .slow_clk_i (slow_clk_i),
    .strobe_o   (cbr_req_o)
  );

  assign refresh_mode_o  = in_susp;
  assign self_ref_req_o  = in_susp && !use_cbr;
  assign mem_block_o     = !sched_en;
  assign norm_sched_en_o = sched_en;
endmodule

// File: rtl/srm_checker.sv
module srm_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic refresh_mode_o,
  input logic self_ref_req_o,
  input logic cbr_req_o,
  input logic mem_block_o,
  input logic norm_sched_en_o
);
  assert_susp_blocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_mode_o |-> mem_block_o);

  assert_exit_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(norm_sched_en_o) |-> ($past(!refresh_mode_o) && !self_ref_req_o));

  assert_self_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_ref_req_o |-> (!cbr_req_o && !norm_sched_en_o));

  assert_cbr_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbr_req_o |=> !cbr_req_o);

  assert_cbr_in_susp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbr_req_o |-> refresh_mode_o);

  assert_unblock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_block_o) |-> norm_sched_en_o);
endmodule

bind susp_refresh_ctrl srm_checker u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .refresh_mode_o  (refresh_mode_o),
  .self_ref_req_o  (self_ref_req_o),
  .cbr_req_o       (cbr_req_o),
  .mem_block_o     (mem_block_o),
  .norm_sched_en_o (norm_sched_en_o)
);

// File: tb/susp_refresh_ctrl_test.sv
`timescale 1ns/1ps
module susp_refresh_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sus_n = 1'b1, res_pos = 1'b0, auto_en = 1'b0, edo = 1'b0, cbr_sel = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic slow = 1'b0;
  logic we = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic mode, self_req, cbr, blk, sched;
  int tests = 0, fails = 0, pulses = 0;

  always #10 clk = ~clk;

  susp_refresh_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .sus_stat_ni(sus_n), .resume_pos_i(res_pos),
    .auto_exit_en_i(auto_en), .mem_edo_i(edo), .edo_cbr_sel_i(cbr_sel),
    .div_sel_i(div_sel), .slow_clk_i(slow), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .refresh_mode_o(mode), .self_ref_req_o(self_req),
    .cbr_req_o(cbr), .mem_block_o(blk), .norm_sched_en_o(sched));

  always @(negedge clk) if (cbr) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic slow_edges(input int n);
    for (int i = 0; i < n; i++) begin
      slow = 1'b1; cyc(4);
      slow = 1'b0; cyc(4);
    end
  endtask

  task automatic watch_exit(output int tm, output int ts);
    tm = -1; ts = -1;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (tm < 0 && !mode) tm = i;
      if (ts < 0 && sched) ts = i;
    end
  endtask

  task automatic check_normal(input string req);
    chk({req, " mode"}, mode, 0);
    chk({req, " block"}, blk, 0);
    chk({req, " sched"}, sched, 1);
    chk({req, " self_ref"}, self_req, 0);
  endtask

  task automatic enter_susp(input logic exp_self, input string tag);
    @(negedge clk); sus_n = 1'b0;
    cyc(6);
    chk({"R2 mode ", tag}, mode, 1);
    chk({"R2 block ", tag}, blk, 1);
    chk({"R2 sched ", tag}, sched, 0);
    chk({"R6 self_ref ", tag}, self_req, exp_self);
  endtask

  task automatic run_case(input logic p, input logic a, input logic e, input logic c);
    int tm, ts, p0;
    logic is_cbr, hw_exit;
    string tag;
    is_cbr  = e && c;
    hw_exit = p && a;
    tag = $sformatf("p%0d a%0d e%0d c%0d", p, a, e, c);
    @(negedge clk); res_pos = p; auto_en = a; edo = e; cbr_sel = c; div_sel = 2'd0;
    enter_susp(!is_cbr, tag);
    p0 = pulses;
    slow_edges(8);
    cyc(6);
    chk({"R7 cbr count ", tag}, pulses - p0, is_cbr ? 2 : 0);
    chk({"R6 self_ref held ", tag}, self_req, !is_cbr);
    // R5: write during suspend must not count
    cfg_wr(8'h7A, 8'h10);
    @(negedge clk); sus_n = 1'b1;
    watch_exit(tm, ts);
    if (hw_exit) begin
      check_normal({"R3 ", tag});
      chk({"R8 order ", tag}, ts - tm, 1);
    end else begin
      chk({"R4/R5 still susp ", tag}, mode, 1);
      chk({"R4 still block ", tag}, blk, 1);
      chk({"R6 self_ref wait ", tag}, self_req, !is_cbr);
      cfg_wr(8'h7B, 8'hFF); cyc(4);
      chk({"R4 wrong addr ", tag}, blk, 1);
      cfg_wr(8'h7A, 8'hEF); cyc(4);
      chk({"R4 bit4 clear ", tag}, mode, 1);
      cfg_wr(8'h7A, 8'h10);
      watch_exit(tm, ts);
      check_normal({"R4 sw exit ", tag});
      chk({"R8 order ", tag}, ts - tm, 1);
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int tm, ts, p0;
    cyc(3);
    check_normal("R1 in reset");
    chk("R1 cbr", cbr, 0);
    rst_n = 1'b1;
    cyc(3);
    check_normal("R1 after reset");
    // R7: slow edges in normal refresh produce no strobe
    edo = 1'b1; cbr_sel = 1'b1;
    p0 = pulses;
    slow_edges(10);
    cyc(4);
    chk("R7 no cbr in normal", pulses - p0, 0);

    for (int m = 0; m < 3; m++)
      for (int p = 0; p < 2; p++)
        for (int a = 0; a < 2; a++)
          run_case(p[0], a[0], m != 0, m == 2);

    // R7: divider sweep, one edge past two full intervals
    for (int s = 0; s < 4; s++) begin
      int lim;
      lim = 4 << s;
      @(negedge clk); edo = 1'b1; cbr_sel = 1'b1; div_sel = s[1:0];
      res_pos = 1'b1; auto_en = 1'b1;
      enter_susp(1'b0, $sformatf("sweep%0d", s));
      p0 = pulses;
      slow_edges(lim - 1);
      cyc(6);
      chk($sformatf("R7 below ratio sel%0d", s), pulses - p0, 0);
      slow_edges(lim + 2);
      cyc(6);
      chk($sformatf("R7 pulses sel%0d", s), pulses - p0, 2);
      @(negedge clk); sus_n = 1'b1;
      watch_exit(tm, ts);
      check_normal("R3 sweep exit");
    end

    // R9: soft reset while waiting for software
    @(negedge clk); edo = 1'b0; cbr_sel = 1'b0; res_pos = 1'b0; auto_en = 1'b1;
    enter_susp(1'b1, "R9 first");
    @(negedge clk); sus_n = 1'b1;
    cyc(8);
    chk("R9 waiting", mode, 1);
    @(negedge clk); sus_n = 1'b0;
    cyc(3);
    @(negedge clk); sus_n = 1'b1;
    cyc(8);
    chk("R9 after soft reset mode", mode, 1);
    chk("R9 after soft reset block", blk, 1);
    chk("R9 self_ref", self_req, 1);
    cfg_wr(8'h7A, 8'h10);
    watch_exit(tm, ts);
    check_normal("R9 sw exit");
    chk("R9 R8 order", ts - tm, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule